// File: doc/BRIEF.md
# Bidirectional Gate Line Scanner

This block is a cycle-based digital model of the row-select side of a matrix display. A single token moves along a chain of row stages, and that token picks which gate line is driven. Two complementary phase inputs pace the chain. The block samples both phases with a fast system clock and moves the token one row for every rising transition of either phase. A frame starts when the start input is high at a rising transition of phase A. A direction input sets whether the token travels toward higher or lower row numbers.

No row output is driven straight from its stage. Each output is gated by an enable pulse, which the controller raises a short time after each phase transition, so a row is only selected inside that window. When the token moves past the last row of the chain, a done flag rises. The controller can read this flag to confirm that the frame scan finished. The flag stays high until the next start.

Top module: `gate_line_scanner`

## Requirements
- R1: A rising transition of `vck_a` seen together with `vst` high loads the token. It goes into row 0 when `scan_down` is 1 and into row ROWS-1 when `scan_down` is 0. Any token already in the chain is replaced. The new state shows one clock after the transition is first sampled.
- R2: A rising transition of `vck_a` or `vck_b` that does not load moves the token by one row. The move is toward the higher index when `scan_down` is 1 and toward the lower index when it is 0. Direction is sampled at every step.
- R3: A full frame selects every row exactly once. The order is 0, 1, ..., ROWS-1 when scanning down and ROWS-1, ..., 0 when scanning up.
- R4: At most one bit of `gate_sel` is high in any cycle.
- R5: `gate_sel[i]` is high only when the token sits in row i and `enb` is high. With `enb` low, every output is low.
- R6: `scan_done` rises one clock after a step carries the token past the far end of the chain. It stays high until the next load.
- R7: Once the token has left the chain, further phase steps without a start keep all outputs low.
- R8: When `rst_n` is low at a clock edge (synchronous, active low), the chain is empty, `scan_done` is 0, and the phase history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vck_a | input | 1 | Vertical phase A; its rising transition is the load slot |
| vck_b | input | 1 | Vertical phase B, complement of phase A |
| vst | input | 1 | Frame start, sampled at the rise of phase A |
| scan_down | input | 1 | 1: rows in ascending index order; 0: descending |
| enb | input | 1 | Output enable window for the selected row |
| gate_sel | output | ROWS | Gate-line select outputs, at most one high |
| scan_done | output | 1 | Token has left the far end of the chain |

## Verification
Full frames are run in both directions and the recorded row order is compared with a strictly ascending and a strictly descending list. This exposes a wrong shift direction, a skipped row or a bad load row. A restart in the middle of a frame tells replacement apart from a second token. A direction flip in the middle of a frame shows that direction is sampled at each step and not only at load. Steps after the token has left the chain, together with cycles where the enable is held low, separate a correct idle, empty chain from a stuck or ungated output.

// File: rtl/gls_pkg.sv
// Shared definitions for the gate line scanner.
// Assumes: none; types only.
package gls_pkg;
    typedef enum logic {
        SCAN_ASCENDING_N = 1'b0,
        SCAN_ASCENDING   = 1'b1
    } scan_order_e;
endpackage

// File: rtl/gls_phase_edge.sv
// Detects rising transitions of the two vertical phase inputs.
// Assumes: phases are held for several clk cycles and are already in the
// clk domain; one rise per phase per period.
module gls_phase_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ph_a,
    input  logic ph_b,
    output logic rise_a,
    output logic step
);
    logic ph_a_q;
    logic ph_b_q;

    // Remember last sampled phase levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_a_q <= 1'b0;
            ph_b_q <= 1'b0;
        end else begin
            ph_a_q <= ph_a;
            ph_b_q <= ph_b;
        end
    end

    // A rise of either phase is one half-period step.
    always_comb begin
        rise_a = ph_a & ~ph_a_q;
        step   = rise_a | (ph_b & ~ph_b_q);
    end
endmodule

// File: rtl/gls_token_chain.sv
// Row stage chain holding a single select token.
// Assumes: load implies step; dir_down sampled on each step.
module gls_token_chain #(
    parameter int ROWS = 225
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            load,
    input  logic            dir_down,
    output logic [ROWS-1:0] token,
    output logic            done
);
    localparam logic [ROWS-1:0] LOW_END  = {{(ROWS-1){1'b0}}, 1'b1};
    localparam logic [ROWS-1:0] HIGH_END = {1'b1, {(ROWS-1){1'b0}}};

    logic [ROWS-1:0] shifted;
    logic            exits;

    // Per-stage neighbour selection for the shift.
    for (genvar i = 0; i < ROWS; i++) begin : g_stage
        logic from_lo;
        logic from_hi;
        if (i == 0) begin : g_first
            assign from_lo = 1'b0;
        end else begin : g_mid_lo
            assign from_lo = token[i-1];
        end
        if (i == ROWS-1) begin : g_last
            assign from_hi = 1'b0;
        end else begin : g_mid_hi
            assign from_hi = token[i+1];
        end
        assign shifted[i] = dir_down ? from_lo : from_hi;
    end

    // Token falls off the end in the current direction.
    assign exits = dir_down ? token[ROWS-1] : token[0];

    // Stage registers and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token <= '0;
            done  <= 1'b0;
        end else if (load) begin
            token <= dir_down ? LOW_END : HIGH_END;
            done  <= 1'b0;
        end else if (step) begin
            token <= shifted;
            if (exits) done <= 1'b1;
        end
    end

    a_r1_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && dir_down) |=> (token == LOW_END));
    a_r1_load_high: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !dir_down) |=> (token == HIGH_END));
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && dir_down && token[0]) |=> token[1]);
    a_r6_done_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && exits) |=> (done && token == '0));
    a_r7_empty_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (token == '0));
endmodule

// File: rtl/gls_row_gate.sv
// Gates every row select with the enable window.
// Assumes: token is one-hot or empty.
module gls_row_gate #(
    parameter int ROWS = 225
) (
    input  logic [ROWS-1:0] token,
    input  logic            enb,
    output logic [ROWS-1:0] gate
);
    // Only the enable window lets the token reach the line.
    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign gate[i] = token[i] & enb;
    end
endmodule

// File: rtl/gate_line_scanner.sv
// Top: bidirectional gate line scanner with two-phase stepping, start
// capture on phase A rise, enable gating and a completion flag.
// Assumes: phase inputs synchronous to clk and complementary.
module gate_line_scanner #(
    parameter int ROWS = 225
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vck_a,
    input  logic            vck_b,
    input  logic            vst,
    input  logic            scan_down,
    input  logic            enb,
    output logic [ROWS-1:0] gate_sel,
    output logic            scan_done
);
    import gls_pkg::*;

    logic            rise_a;
    logic            step;
    logic            load;
    logic [ROWS-1:0] token;
    scan_order_e     order;

    assign order = scan_order_e'(scan_down);
    assign load  = rise_a & vst;

    gls_phase_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ph_a   (vck_a),
        .ph_b   (vck_b),
        .rise_a (rise_a),
        .step   (step)
    );

    gls_token_chain #(.ROWS(ROWS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load),
        .dir_down (order == SCAN_ASCENDING),
        .token    (token),
        .done     (scan_done)
    );

    gls_row_gate #(.ROWS(ROWS)) u_gate (
        .token (token),
        .enb   (enb),
        .gate  (gate_sel)
    );

    a_r4_single_row: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_sel));
    a_r5_enable_window: assert property (@(posedge clk) disable iff (!rst_n)
        !enb |-> (gate_sel == '0));
    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (scan_done == 1'b0 && gate_sel == '0));
endmodule

// File: tb/gate_line_scanner_tb_top.sv
module gate_line_scanner_tb_top;
    localparam int ROWS = 225;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            vck_a = 1'b0;
    logic            vck_b = 1'b1;
    logic            vst = 1'b0;
    logic            scan_down = 1'b1;
    logic            enb = 1'b0;
    logic [ROWS-1:0] gate_sel;
    logic            scan_done;

    int checks = 0;
    int fails  = 0;

    // behavioural reference
    int m_pos = -1;
    int m_last = -1;
    bit m_done = 1'b0;
    bit m_pa = 1'b0;
    bit m_pb = 1'b0;
    int visits[$];

    always #5 clk = ~clk;

    gate_line_scanner #(.ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .vck_a(vck_a), .vck_b(vck_b),
        .vst(vst), .scan_down(scan_down), .enb(enb),
        .gate_sel(gate_sel), .scan_done(scan_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model update, same inputs as the design sees
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = -1; m_done = 1'b0; m_pa = 1'b0; m_pb = 1'b0; m_last = -1;
        end else begin
            bit ra, rb;
            ra = vck_a && !m_pa;
            rb = vck_b && !m_pb;
            if (ra && vst) begin
                m_pos = scan_down ? 0 : ROWS-1;
                m_done = 1'b0;
                m_last = -1;
            end else if ((ra || rb) && m_pos >= 0) begin
                if (scan_down) begin
                    if (m_pos == ROWS-1) begin m_pos = -1; m_done = 1'b1; end
                    else m_pos++;
                end else begin
                    if (m_pos == 0) begin m_pos = -1; m_done = 1'b1; end
                    else m_pos--;
                end
            end
            if (m_pos >= 0 && m_pos != m_last) visits.push_back(m_pos);
            m_last = m_pos;
            m_pa = vck_a; m_pb = vck_b;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        logic [ROWS-1:0] exp_g;
        exp_g = '0;
        if (m_pos >= 0 && enb) exp_g[m_pos] = 1'b1;
        // R2 and R5: position and enable gating each cycle
        check(gate_sel === exp_g, "R2", "gate_sel index",
              (gate_sel == 0) ? 32'hFFFF : $clog2(gate_sel + 1) - 1,
              (exp_g == 0) ? 32'hFFFF : $clog2(exp_g + 1) - 1);
        // R4: never more than one row
        check($countones(gate_sel) <= 1, "R4", "ones in gate_sel",
              $countones(gate_sel), 1);
        // R6: completion flag
        check(scan_done === m_done, "R6", "scan_done", scan_done, m_done);
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    // one half period: toggle phases, enable window a bit later
    task automatic half(input bit start);
        if (start) vst = 1'b1;
        vck_a = ~vck_a;
        vck_b = ~vck_b;
        tick(1);
        vst = 1'b0;
        enb = 1'b1;
        tick(2);
        enb = 1'b0;
        tick(1);
    endtask

    // bring phase A low so the next half period is a phase A rise
    task automatic align_a_low();
        if (vck_a) half(1'b0);
    endtask

    task automatic check_order(input bit down, input string req);
        bit ok;
        ok = (visits.size() == ROWS);
        for (int k = 0; k < visits.size() && ok; k++)
            if (visits[k] != (down ? k : ROWS-1-k)) ok = 1'b0;
        check(ok, req, "row order / count", visits.size(), ROWS);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        // R8: reset state
        check(gate_sel === '0, "R8", "gate_sel in reset", gate_sel[31:0], 0);
        check(scan_done === 1'b0, "R8", "scan_done in reset", scan_done, 0);
        rst_n = 1'b1;
        tick(2);

        // R3: full downward frame
        scan_down = 1'b1;
        align_a_low();
        visits.delete();
        half(1'b1);
        check(visits.size() == 1 && visits[0] == 0, "R1", "load row down",
              visits[0], 0);
        for (int k = 0; k < ROWS + 4; k++) half(1'b0);
        check_order(1'b1, "R3");
        check(scan_done === 1'b1, "R6", "done after down frame", scan_done, 1);
        // R7: idle after exit
        for (int k = 0; k < 6; k++) half(1'b0);
        enb = 1'b1; tick(1);
        check(gate_sel === '0, "R7", "outputs after exit", gate_sel[31:0], 0);
        enb = 1'b0; tick(1);

        // R3: full upward frame
        scan_down = 1'b0;
        align_a_low();
        visits.delete();
        half(1'b1);
        check(visits.size() == 1 && visits[0] == ROWS-1, "R1", "load row up",
              visits[0], ROWS-1);
        check(scan_done === 1'b0, "R6", "done cleared by load", scan_done, 0);
        for (int k = 0; k < ROWS + 4; k++) half(1'b0);
        check_order(1'b0, "R3");

        // R1: restart mid frame replaces token
        scan_down = 1'b1;
        align_a_low();
        half(1'b1);
        for (int k = 0; k < 9; k++) half(1'b0);
        align_a_low();
        half(1'b1);
        enb = 1'b1; tick(1);
        check(gate_sel[0] === 1'b1 && $countones(gate_sel) == 1, "R1",
              "restart row", $countones(gate_sel), 1);
        // R5: enable low blanks selected row
        enb = 1'b0; tick(1);
        check(gate_sel === '0, "R5", "enable low", gate_sel[31:0], 0);

        // R2: direction flip mid frame
        for (int k = 0; k < 5; k++) half(1'b0);
        scan_down = 1'b0;
        half(1'b0);
        enb = 1'b1; tick(1);
        check(gate_sel[4] === 1'b1, "R2", "reverse step row", gate_sel[4], 1);
        enb = 1'b0;
        for (int k = 0; k < 8; k++) half(1'b0);
        check(scan_done === 1'b1, "R6", "done on low end exit", scan_done, 1);

        // R8: reset mid frame
        scan_down = 1'b1;
        align_a_low();
        half(1'b1);
        rst_n = 1'b0; tick(1);
        rst_n = 1'b1; enb = 1'b1; tick(1);
        check(gate_sel === '0, "R8", "reset clears token", gate_sel[31:0], 0);
        enb = 1'b0; tick(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule